// File: doc/BRIEF.md
# Synchronization Storage Window Decoder

This block holds the two 64-bit configuration words that place and size the address window through which software reaches an array of synchronization storage cells. The cells are a mix of FIFO cells and semaphore cells. Software reads and writes the configuration words through a small register port. Each word sits 8 bytes apart, so the word index is the port address shifted right by three.

Each write that actually alters a stored word triggers a reconfiguration, which updates the applied window base, window size and enable. The size changes only when the new candidate size is a power of two. Independently of the register port, the block decodes a storage access address into two results. The first is a cell index, using a programmable stride of 2^(7+grain) bytes and clamped to the last cell. The second is a 4-bit access-view code, taken from address bits 6:3 of the window offset.

Top module: `sync_window_decoder`

## Requirements
- R1: After reset, word 0 reads 0. Word 1 reads 0xC00 with the total cell count placed from bit 20 (0x0200_0C00 for 32 cells). The applied base is 0, the size is 4096 and the enable is 0.
- R2: The word index is cfg_addr shifted right by 3, so address bits 2:0 are ignored. In word 0 only bits 31:10 (base) and bit 0 (enable) are writable, and every other bit reads 0.
- R3: In word 1 only bits 16:10 (mask) and bits 2:0 (grain) are writable. Every other bit, including the cell-count field from bit 20, keeps its value across any write.
- R4: A write to any word index other than 0 or 1 changes nothing, and a read of such an index returns 0.
- R5: On the edge that stores a changed word, win_base becomes word 0 bits 31:10 (with low bits zero) and win_en becomes word 0 bit 0.
- R6: On reconfiguration the candidate size is 1024 plus the word-1 mask field (bits 16:10 in place). It becomes win_size only if it is a power of two; otherwise win_size keeps its previous value.
- R7: win_base, win_size and win_en stay unchanged in every cycle without a write that changes a stored word, including writes that touch only fixed bits.
- R8: cell_idx is (acc_addr - win_base) shifted right by 7 plus the word-1 grain field (stride of 128, 256, ... 16384 bytes).
- R9: A computed cell index at or above the total cell count (N_FIFO + N_SEM) is output as the last cell, count minus 1.
- R10: view_code equals bits 6:3 of (acc_addr - win_base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Register port access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | AW | Register port byte address |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data (combinational, 0 when not reading) |
| acc_addr | input | 32 | Storage access address to decode |
| win_base | output | 32 | Applied window base |
| win_size | output | 18 | Applied window size in bytes |
| win_en | output | 1 | Applied window enable |
| cell_idx | output | CIW | Selected cell (clamped) |
| view_code | output | 4 | Access view code |

## Verification
The hardest situation to reach is a reconfiguration in which the size is rejected: the mask changes but the new size is not a power of two, so base and enable update while the size holds. The stimulus first programs a valid mask, then writes a mask that yields 0xC00, and checks that the size keeps the older value. The clamp is reached by choosing the widest mask with the smallest grain and addressing offsets at, just below, and well past the last cell boundary. A write that touches only fixed bits shows that no reconfiguration happens when nothing stored changes.

// File: rtl/sync_window_pkg.sv
package sync_window_pkg;
    localparam int WORD_W      = 64;
    localparam int ADDR_W32    = 32;
    localparam int SIZE_W      = 18;
    localparam int GRAIN_W     = 3;
    localparam int VIEW_W      = 4;
    localparam int VIEW_LSB    = 3;
    localparam int STRIDE_LOG0 = 7;
    localparam int BASE_LSB    = 10;
    localparam int COUNT_LSB   = 20;
    localparam int MIN_SIZE    = 1024;
    localparam int RESET_SPAN  = 4096;

    localparam logic [WORD_W-1:0] W0_WMASK   = 64'h0000_0000_FFFF_FC01;
    localparam logic [WORD_W-1:0] W1_MASKFLD = 64'h0000_0000_0001_FC00;
    localparam logic [WORD_W-1:0] W1_GRAIN   = 64'h0000_0000_0000_0007;
    localparam logic [WORD_W-1:0] W1_WMASK   = W1_MASKFLD | W1_GRAIN;

    typedef struct packed {
        logic [WORD_W-1:0]   w0;
        logic [WORD_W-1:0]   w1;
        logic [ADDR_W32-1:0] base;
        logic [SIZE_W-1:0]   size;
        logic                en;
    } win_state_t;
endpackage

// File: rtl/sync_window_regs.sv
module sync_window_regs
    import sync_window_pkg::*;
#(
    parameter int NCELLS = 32,
    parameter int AW     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic                write,
    input  logic [AW-1:0]       addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic [ADDR_W32-1:0] base,
    output logic [SIZE_W-1:0]   size,
    output logic                en,
    output logic [GRAIN_W-1:0]  grain
);
    localparam int IDX_W = AW - 3;
    localparam logic [WORD_W-1:0] RST_W1 =
        (WORD_W'(RESET_SPAN - 1) & W1_MASKFLD) | (WORD_W'(NCELLS) << COUNT_LSB);
    localparam logic [SIZE_W-1:0] RST_SIZE =
        SIZE_W'(MIN_SIZE) + SIZE_W'((RESET_SPAN - 1) & int'(W1_MASKFLD));

    win_state_t st_d, st_q;
    logic [IDX_W-1:0]  word_idx;
    logic              changed_d;
    logic [SIZE_W-1:0] cand_size;

    assign word_idx = addr[AW-1:3];

    always_comb begin
        st_d      = st_q;
        cand_size = '0;
        if (valid && write) begin
            if (word_idx == IDX_W'(0))
                st_d.w0 = (wdata & W0_WMASK) | (st_q.w0 & ~W0_WMASK);
            else if (word_idx == IDX_W'(1))
                st_d.w1 = (wdata & W1_WMASK) | (st_q.w1 & ~W1_WMASK);
        end
        changed_d = (st_d.w0 != st_q.w0) || (st_d.w1 != st_q.w1);
        if (changed_d) begin
            cand_size = SIZE_W'(MIN_SIZE) + SIZE_W'(st_d.w1 & W1_MASKFLD);
            if ((cand_size & (cand_size - SIZE_W'(1))) == '0)
                st_d.size = cand_size;
            st_d.base = {st_d.w0[ADDR_W32-1:BASE_LSB], {BASE_LSB{1'b0}}};
            st_d.en   = st_d.w0[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.w0   <= '0;
            st_q.w1   <= RST_W1;
            st_q.base <= '0;
            st_q.size <= RST_SIZE;
            st_q.en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (valid && !write) begin
            if (word_idx == IDX_W'(0))      rdata = st_q.w0;
            else if (word_idx == IDX_W'(1)) rdata = st_q.w1;
        end
    end

    assign base  = st_q.base;
    assign size  = st_q.size;
    assign en    = st_q.en;
    assign grain = st_q.w1[GRAIN_W-1:0];

    // R2: fixed bits of word 0 never become set
    p_w0_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.w0 & ~W0_WMASK) == '0);

    // R3: non-writable bits of word 1 hold across writes
    p_w1_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.w1 & ~W1_WMASK));

    // R6: the applied size is always a power of two
    p_size_pow2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.size) == 1);

    // R7: no changing write, no change of applied window
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !changed_d |=> ($stable(st_q.base) && $stable(st_q.size) && $stable(st_q.en)));
endmodule

// File: rtl/sync_window_cellsel.sv
module sync_window_cellsel
    import sync_window_pkg::*;
#(
    parameter int NCELLS = 32,
    parameter int CIW    = 5
) (
    input  logic [ADDR_W32-1:0] acc_addr,
    input  logic [ADDR_W32-1:0] base,
    input  logic [GRAIN_W-1:0]  grain,
    output logic [CIW-1:0]      cell_idx,
    output logic [VIEW_W-1:0]   view_code
);
    localparam int SH_W = 5;
    localparam logic [ADDR_W32-1:0] LAST = ADDR_W32'(NCELLS - 1);

    logic [ADDR_W32-1:0] offset;
    logic [SH_W-1:0]     shamt;
    logic [ADDR_W32-1:0] raw_idx;

    always_comb begin
        offset  = acc_addr - base;
        shamt   = SH_W'(STRIDE_LOG0) + SH_W'(grain);
        raw_idx = offset >> shamt;
        if (raw_idx > LAST) cell_idx = CIW'(LAST);
        else                cell_idx = raw_idx[CIW-1:0];
        view_code = offset[VIEW_LSB +: VIEW_W];
    end
endmodule

// File: rtl/sync_window_decoder.sv
module sync_window_decoder
    import sync_window_pkg::*;
#(
    parameter int N_FIFO = 16,
    parameter int N_SEM  = 16,
    parameter int AW     = 6,
    parameter int NCELLS = N_FIFO + N_SEM,
    parameter int CIW    = (NCELLS > 1) ? $clog2(NCELLS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_valid,
    input  logic                cfg_write,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [63:0]         cfg_wdata,
    output logic [63:0]         cfg_rdata,
    input  logic [31:0]         acc_addr,
    output logic [31:0]         win_base,
    output logic [17:0]         win_size,
    output logic                win_en,
    output logic [CIW-1:0]      cell_idx,
    output logic [3:0]          view_code
);
    logic [GRAIN_W-1:0] grain;

    sync_window_regs #(.NCELLS(NCELLS), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (cfg_valid),
        .write (cfg_write),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .base  (win_base),
        .size  (win_size),
        .en    (win_en),
        .grain (grain)
    );

    sync_window_cellsel #(.NCELLS(NCELLS), .CIW(CIW)) u_sel (
        .acc_addr  (acc_addr),
        .base      (win_base),
        .grain     (grain),
        .cell_idx  (cell_idx),
        .view_code (view_code)
    );

    // R9: selected cell never exceeds the last cell
    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cell_idx) <= 32'(NCELLS - 1));
endmodule

// File: tb/tb_sync_window_decoder.sv
module tb_sync_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic [31:0] acc_addr = '0;
    logic [31:0] win_base;
    logic [17:0] win_size;
    logic        win_en;
    logic [4:0]  cell_idx;
    logic [3:0]  view_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sync_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_addr(acc_addr), .win_base(win_base), .win_size(win_size),
        .win_en(win_en), .cell_idx(cell_idx), .view_code(view_code)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [63:0] data;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h00, 64'h0,                    "R1"},
        '{1'b0, 6'h08, 64'h0000_0000_0200_0C00,  "R1"},
        '{1'b1, 6'h05, 64'hFFFF_FFFF_FFFF_FFFF,  "R2"},
        '{1'b0, 6'h00, 64'h0000_0000_FFFF_FC01,  "R2"},
        '{1'b0, 6'h07, 64'h0000_0000_FFFF_FC01,  "R2"},
        '{1'b1, 6'h08, 64'hFFFF_FFFF_FFFF_FFFF,  "R3"},
        '{1'b0, 6'h0F, 64'h0000_0000_0201_FC07,  "R3"},
        '{1'b1, 6'h08, 64'h0,                    "R3"},
        '{1'b0, 6'h08, 64'h0000_0000_0200_0000,  "R3"},
        '{1'b1, 6'h10, 64'hFFFF_FFFF_FFFF_FFFF,  "R4"},
        '{1'b0, 6'h10, 64'h0,                    "R4"},
        '{1'b1, 6'h38, 64'h1234_5678_9ABC_DEF0,  "R4"},
        '{1'b0, 6'h38, 64'h0,                    "R4"},
        '{1'b0, 6'h00, 64'h0000_0000_FFFF_FC01,  "R4"}
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_valid = 1'b0;
    endtask

    task automatic decode(input string req, input logic [31:0] a,
                          input logic [4:0] exp_idx, input logic [3:0] exp_view);
        @(negedge clk);
        acc_addr = a;
        #1;
        check(req, 64'(cell_idx), 64'(exp_idx));
        check(req, 64'(view_code), 64'(exp_view));
    endtask

    initial begin
        logic [63:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 applied window after reset
        check("R1", 64'(win_base), 64'h0);
        check("R1", 64'(win_size), 64'd4096);
        check("R1", 64'(win_en), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else begin
                rd(VEC[i].addr, rv);
                check(string'(VEC[i].tag), rv, VEC[i].data);
            end
        end

        // R5 base and enable follow word 0
        wr(6'h00, 64'h0001_2345_6789_ABCD);
        #1;
        check("R5", 64'(win_base), 64'h6789_A800);
        check("R5", 64'(win_en), 64'h1);
        wr(6'h00, 64'h0);
        #1;
        check("R5", 64'(win_base), 64'h0);
        check("R5", 64'(win_en), 64'h0);

        // R6 size from mask, only powers of two accepted
        wr(6'h08, 64'h400);
        #1 check("R6", 64'(win_size), 64'h800);
        wr(6'h08, 64'h800);
        #1 check("R6", 64'(win_size), 64'h800);
        wr(6'h08, 64'h1FC00);
        #1 check("R6", 64'(win_size), 64'h20000);

        // R7 write touching only fixed bits: nothing reconfigures
        wr(6'h08, 64'hFFFF_0000_0000_0000 | 64'h1FC00);
        #1 check("R7", 64'(win_size), 64'h20000);
        wr(6'h00, 64'h0000_0000_0000_03FE);
        #1 check("R7", 64'(win_en), 64'h0);
        check("R7", 64'(win_base), 64'h0);

        // R8 R9 R10 decode with base 0x10000, grain 0
        wr(6'h00, 64'h0001_0001);
        wr(6'h08, 64'h1FC00);
        decode("R8", 32'h0001_01A8, 5'd3, 4'd5);
        decode("R10", 32'h0001_0F80, 5'd31, 4'd0);
        decode("R9", 32'h0001_1000, 5'd31, 4'd0);
        decode("R9", 32'h0001_1408, 5'd31, 4'd1);
        decode("R8", 32'h0001_0F08, 5'd30, 4'd1);
        wr(6'h08, 64'h1FC02);
        decode("R8", 32'h0001_0E78, 5'd7, 4'd15);
        wr(6'h08, 64'h1FC07);
        decode("R10", 32'h0001_4040, 5'd1, 4'd8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule